// File: doc/BRIEF.md
# Normalized Busy Ratio Calculator

This block turns a pair of free-running activity counts into one load figure for a clock-scaling or power governor. When a sample is requested it takes a snapshot of the busy-cycle count, the total-cycle count and a counter-overflow flag. It then returns the busy share of the window on a scale of 0 to 1000 and sends one-cycle reset pulses to both counters, so the next window starts from zero.

A measurement that cannot be trusted reads as fully loaded (1000). This covers an overflow seen during the window, an empty window, and a busy count larger than the window. When the overflow flag caused the saturation, the block also sends an acknowledge pulse that clears it. A unit that is powered down reads as 0 and its counters are left alone. Only the normal case runs the internal restoring divider, which produces one quotient bit per clock. The other outcomes arrive in the cycle after the request.

Top module: `busy_ratio_norm`

## Requirements
- R1: With `pwr_on` low, an accepted request gives `load_norm` = 0 with `load_valid` one cycle later, and no pulse on `busy_count_clr`, `total_count_clr` or `ovf_ack`.
- R2: With power on, no overflow, a non-zero total and busy not above total, the result is floor(busy × 1000 / total). It appears CNT_W + 12 cycles after the request edge (44 cycles for 32-bit counts) and never exceeds 1000.
- R3: With power on and `ovf_pending` high, the result is 1000 and `ovf_ack` pulses high for exactly one cycle.
- R4: With power on, no overflow and a total count of zero, the result is 1000.
- R5: With power on, no overflow and a busy count above the total count, the result is 1000.
- R6: The overflow flag outranks the other saturation checks. An overflow together with a zero total or an oversized busy count still produces the `ovf_ack` pulse.
- R7: Every request accepted with power on gives exactly one cycle of `busy_count_clr` and `total_count_clr`, in the cycle after the request edge, whatever the outcome.
- R8: `div_active` is high while a division runs. A request that arrives during that time is ignored: it produces no result and no pulse.
- R9: `load_valid` lasts one cycle for each accepted request. Powered-off and saturated results appear one cycle after the request edge, without running the divider.
- R10: Full-range 32-bit counts are handled without overflow: 0xFFFFFFFE over 0xFFFFFFFF gives 999, equal counts give 1000, and 0x80000000 over 0xFFFFFFFF gives 500.
- R11: After reset, `load_valid`, `div_active`, `load_norm` and all three pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_req | input | 1 | One-cycle request to take a sample |
| pwr_on | input | 1 | High when the monitored unit is powered |
| busy_count | input | CNT_W | Busy-cycle count of the current window |
| total_count | input | CNT_W | Total-cycle count of the current window |
| ovf_pending | input | 1 | Counter overflow seen during the window |
| busy_count_clr | output | 1 | Reset pulse to the busy counter |
| total_count_clr | output | 1 | Reset pulse to the total counter |
| ovf_ack | output | 1 | Clear pulse to the overflow flag |
| load_norm | output | 10 | Normalized load, 0 to 1000 |
| load_valid | output | 1 | One-cycle strobe marking `load_norm` |
| div_active | output | 1 | Division in progress; requests ignored |

## Verification
The assertions assume that `sample_req`, `pwr_on`, `ovf_pending` and the counts are driven to known values from reset onward. They also assume these inputs are stable around the clock edge on which a request is taken, because several properties look back one cycle at the request and the power state. The stimulus changes inputs only on the falling edge and holds `sample_req` low from time zero. It pulses the request for exactly one cycle. The only request it raises during a running division is the deliberate one that checks the ignore rule.

// File: rtl/busy_ratio_pkg.sv
package busy_ratio_pkg;
  // full-scale value of the normalized load and the width that holds it
  localparam int unsigned FULL_SCALE = 1000;
  localparam int unsigned NORM_W     = $clog2(FULL_SCALE + 1);

  // outcome chosen for a sample
  typedef enum logic [1:0] {
    OUT_OFF = 2'd0,   // unit unpowered: result zero, counters untouched
    OUT_SAT = 2'd1,   // measurement untrusted: result full scale
    OUT_DIV = 2'd2    // normal: run the divider
  } out_kind_e;
endpackage

// File: rtl/ratio_classify.sv
module ratio_classify
  import busy_ratio_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             pwr_on,
  input  logic             ovf,
  input  logic [CNT_W-1:0] busy_cnt,
  input  logic [CNT_W-1:0] total_cnt,
  output out_kind_e        kind,
  output logic             ack_ovf
);
  // priority: power state, then overflow, then count sanity
  always_comb begin
    ack_ovf = 1'b0;
    if (!pwr_on) begin
      kind = OUT_OFF;
    end else if (ovf) begin
      kind    = OUT_SAT;
      ack_ovf = 1'b1;
    end else if ((total_cnt == '0) || (busy_cnt > total_cnt)) begin
      kind = OUT_SAT;
    end else begin
      kind = OUT_DIV;
    end
  end
endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int unsigned DVD_W = 42,
  parameter int unsigned DVS_W = 32,
  parameter int unsigned Q_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [Q_W-1:0]   quotient,
  output logic             done,
  output logic             running
);
  localparam int unsigned STEP_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  quo_q, quo_d;
  logic [DVS_W-1:0]  rem_q, rem_d;
  logic [DVS_W-1:0]  dvs_q, dvs_d;
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic              done_q, done_d;
  logic [DVS_W:0]    shifted;
  logic              fits;

  // one restoring shift-subtract step per clock
  always_comb begin
    quo_d   = quo_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    shifted = {rem_q, quo_q[DVD_W-1]};
    fits    = (shifted >= {1'b0, dvs_q});
    if (start) begin
      quo_d = dividend;
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = STEP_W'(DVD_W);
    end else if (cnt_q != '0) begin
      // remainder stays below the divisor, so DVS_W bits suffice
      rem_d  = fits ? (shifted[DVS_W-1:0] - dvs_q) : shifted[DVS_W-1:0];
      quo_d  = {quo_q[DVD_W-2:0], fits};
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == STEP_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign quotient = quo_q[Q_W-1:0];
  assign done     = done_q;
  assign running  = (cnt_q != '0);

  // R8: the controller never restarts a division already in flight
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));
endmodule

// File: rtl/busy_ratio_norm.sv
module busy_ratio_norm
  import busy_ratio_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_req,
  input  logic              pwr_on,
  input  logic [CNT_W-1:0]  busy_count,
  input  logic [CNT_W-1:0]  total_count,
  input  logic              ovf_pending,
  output logic              busy_count_clr,
  output logic              total_count_clr,
  output logic              ovf_ack,
  output logic [NORM_W-1:0] load_norm,
  output logic              load_valid,
  output logic              div_active
);
  localparam int unsigned PROD_W = CNT_W + NORM_W;
  localparam logic [NORM_W-1:0] FULL_V = NORM_W'(FULL_SCALE);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  out_kind_e         kind;
  logic              ack_ovf;
  logic [PROD_W-1:0] scaled_busy;
  logic [NORM_W-1:0] div_quot;
  logic              div_done;
  logic              div_run;
  logic              div_start;

  ratio_classify #(.CNT_W(CNT_W)) u_classify (
    .pwr_on    (pwr_on),
    .ovf       (ovf_pending),
    .busy_cnt  (busy_count),
    .total_cnt (total_count),
    .kind      (kind),
    .ack_ovf   (ack_ovf)
  );

  // wide enough for a full-range count times full scale
  assign scaled_busy = PROD_W'(busy_count) * PROD_W'(FULL_SCALE);

  ratio_divider #(.DVD_W(PROD_W), .DVS_W(CNT_W), .Q_W(NORM_W)) u_divider (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (div_start),
    .dividend (scaled_busy),
    .divisor  (total_count),
    .quotient (div_quot),
    .done     (div_done),
    .running  (div_run)
  );

  logic              busy_q, busy_d;
  logic              vld_q, vld_d;
  logic [NORM_W-1:0] val_q, val_d;
  logic              val_en;
  logic              brst_q, brst_d;
  logic              trst_q, trst_d;
  logic              ack_q, ack_d;
  logic              accept;

  assign accept = sample_req && !busy_q;

  always_comb begin
    busy_d    = busy_q;
    vld_d     = 1'b0;
    val_d     = val_q;
    val_en    = 1'b0;
    brst_d    = 1'b0;
    trst_d    = 1'b0;
    ack_d     = 1'b0;
    div_start = 1'b0;
    if (accept) begin
      unique case (kind)
        OUT_OFF: begin
          val_d  = '0;
          val_en = 1'b1;
          vld_d  = 1'b1;
        end
        OUT_SAT: begin
          val_d  = FULL_V;
          val_en = 1'b1;
          vld_d  = 1'b1;
          brst_d = 1'b1;
          trst_d = 1'b1;
          ack_d  = ack_ovf;
        end
        default: begin
          busy_d    = 1'b1;
          div_start = 1'b1;
          brst_d    = 1'b1;
          trst_d    = 1'b1;
        end
      endcase
    end else if (div_done) begin
      val_d  = div_quot;
      val_en = 1'b1;
      vld_d  = 1'b1;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      brst_q <= 1'b0;
      trst_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      vld_q  <= vld_d;
      brst_q <= brst_d;
      trst_q <= trst_d;
      ack_q  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  val_q <= '0;
    else if (val_en)  val_q <= val_d;
  end

  assign busy_count_clr  = brst_q;
  assign total_count_clr = trst_q;
  assign ovf_ack         = ack_q;
  assign load_norm       = val_q;
  assign load_valid      = vld_q;
  assign div_active      = busy_q;

  // R1: unpowered sample reads zero and leaves the counters alone
  assert_off_zero_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sample_req && !div_active && !pwr_on) |=>
      (load_valid && load_norm == '0 && !busy_count_clr && !total_count_clr && !ovf_ack));

  // R2: a reported load never exceeds full scale
  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_valid |-> (load_norm <= FULL_V));

  // R3: overflow forces full scale and acknowledges the flag
  assert_ovf_sat_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sample_req && !div_active && pwr_on && ovf_pending) |=>
      (ovf_ack && load_valid && load_norm == FULL_V));

  // R7: counter resets only follow an accepted, powered request
  assert_clr_origin_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy_count_clr |-> ($past(sample_req) && $past(pwr_on) && !$past(div_active)));

  // R8: nothing is accepted during a division
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    div_active |=> !busy_count_clr);

  // R9: the strobe lasts a single cycle
  assert_vld_single_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_valid |=> !load_valid);

  // R8: the busy flag agrees with the divider's own activity
  assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    div_run |-> div_active);
endmodule

// File: tb/busy_ratio_norm_test.sv
module busy_ratio_norm_test;
  localparam int CNT_W   = 32;
  localparam int DIV_LAT = CNT_W + 10 + 2;

  logic             clk;
  logic             rst_n;
  logic             sample_req;
  logic             pwr_on;
  logic [CNT_W-1:0] busy_count;
  logic [CNT_W-1:0] total_count;
  logic             ovf_pending;
  logic             busy_count_clr;
  logic             total_count_clr;
  logic             ovf_ack;
  logic [9:0]       load_norm;
  logic             load_valid;
  logic             div_active;

  busy_ratio_norm #(.CNT_W(CNT_W)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_req      (sample_req),
    .pwr_on          (pwr_on),
    .busy_count      (busy_count),
    .total_count     (total_count),
    .ovf_pending     (ovf_pending),
    .busy_count_clr  (busy_count_clr),
    .total_count_clr (total_count_clr),
    .ovf_ack         (ovf_ack),
    .load_norm       (load_norm),
    .load_valid      (load_valid),
    .div_active      (div_active)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int    exp_val;
    int    req_cyc;
    int    lat;
    string tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  int    nres  = 0;
  int    n_brst = 0, n_trst = 0, n_ack = 0;
  bit    prev_vld = 0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pulse counters and scoreboard compare
  always @(negedge clk) begin
    if (busy_count_clr)  n_brst++;
    if (total_count_clr) n_trst++;
    if (ovf_ack)         n_ack++;
    if (load_valid && prev_vld) check(0, "R9 strobe longer than one cycle", 2, 1);
    prev_vld = load_valid;
    if (load_valid) begin
      nres++;
      if (q.size() == 0) begin
        check(0, "R8 unexpected result", int'(load_norm), -1);
      end else begin
        item_t it;
        it = q.pop_front();
        check(int'(load_norm) == it.exp_val, {it.tag, " value"}, int'(load_norm), it.exp_val);
        check(cyc - it.req_cyc == it.lat, "R9/R2 latency", cyc - it.req_cyc, it.lat);
      end
    end
  end

  // model from the requirements
  function automatic int model(input logic [31:0] b, input logic [31:0] t,
                               input bit ov, input bit pw);
    longint unsigned p;
    if (!pw) return 0;
    if (ov) return 1000;
    if (t == 0 || b > t) return 1000;
    p = longint'(b) * 1000;
    return int'(p / longint'(t));
  endfunction

  task automatic run_case(input logic [31:0] b, input logic [31:0] t, input bit ov,
                          input bit pw, input string tag, input bit poke);
    item_t it;
    int    b0, t0, a0, tgt, ev;
    bit    div_case;
    ev       = model(b, t, ov, pw);
    div_case = pw && !ov && t != 0 && b <= t;
    @(negedge clk);
    b0 = n_brst; t0 = n_trst; a0 = n_ack; tgt = nres + 1;
    busy_count = b; total_count = t; ovf_pending = ov; pwr_on = pw;
    sample_req = 1'b1;
    it.exp_val = ev; it.req_cyc = cyc; it.lat = div_case ? DIV_LAT : 1; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    sample_req = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      check(div_active == 1'b1, "R8 busy during division", int'(div_active), 1);
      busy_count = 32'd3; total_count = 32'd0; ovf_pending = 1'b1; pwr_on = 1'b1;
      sample_req = 1'b1;
      @(negedge clk);
      sample_req = 1'b0;
    end
    wait (nres >= tgt);
    repeat (3) @(negedge clk);
    check(nres == tgt, "R8 result count", nres, tgt);
    check(n_brst - b0 == (pw ? 1 : 0), "R7 busy counter reset pulses", n_brst - b0, pw ? 1 : 0);
    check(n_trst - t0 == (pw ? 1 : 0), "R7 total counter reset pulses", n_trst - t0, pw ? 1 : 0);
    check(n_ack - a0 == ((pw && ov) ? 1 : 0), "R3/R6 overflow ack pulses",
          n_ack - a0, (pw && ov) ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0; sample_req = 1'b0; pwr_on = 1'b0;
    busy_count = '0; total_count = '0; ovf_pending = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(load_valid == 0 && div_active == 0, "R11 valid/active after reset",
          int'({load_valid, div_active}), 0);
    check(load_norm == 0, "R11 load after reset", int'(load_norm), 0);
    check(!busy_count_clr && !total_count_clr && !ovf_ack, "R11 pulses after reset",
          int'({busy_count_clr, total_count_clr, ovf_ack}), 0);

    run_case(32'd10,   32'd100,  1'b1, 1'b0, "R1 powered off", 0);
    run_case(32'd250,  32'd1000, 1'b0, 1'b1, "R2 quarter load", 0);
    run_case(32'd1,    32'd3,    1'b0, 1'b1, "R2 rounding down", 0);
    run_case(32'd7,    32'd7,    1'b0, 1'b1, "R2 fully busy", 0);
    run_case(32'd0,    32'd5,    1'b0, 1'b1, "R2 idle", 0);
    run_case(32'd10,   32'd100,  1'b1, 1'b1, "R3 overflow", 0);
    run_case(32'd0,    32'd0,    1'b0, 1'b1, "R4 zero total", 0);
    run_case(32'd6,    32'd5,    1'b0, 1'b1, "R5 busy above total", 0);
    run_case(32'd0,    32'd0,    1'b1, 1'b1, "R6 overflow with zero total", 0);
    run_case(32'd9,    32'd5,    1'b1, 1'b1, "R6 overflow with busy above total", 0);
    run_case(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 1'b1, "R10 near full range", 0);
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R10 full range equal", 0);
    run_case(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, "R10 half range", 0);
    run_case(32'd3,    32'd8,    1'b0, 1'b1, "R8 request during division", 1);
    run_case(32'd5,    32'd0,    1'b0, 1'b0, "R1 powered off zero total", 0);

    check(q.size() == 0, "R8 scoreboard drained", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule